// File: doc/BRIEF.md
# SMI/PME Event Aggregator

This block collects interrupt events from thirteen on-chip device sources into two status registers. Each status bit has an enable bit beside it. The block folds the enabled events into one system management interrupt (SMI) and one power-management event (PME).

Each status bit keeps one of three clear behaviours, fixed by parameter masks:

- **Live:** the bit follows its source.
- **Read-clear:** the bit drops after a read of its register.
- **Sticky:** the bit is kept until software writes a 1 to it.

Ring and consumer-IR events are also latched into a separate sticky PME status register. A sleep-request input can be allowed to raise SMI.

The SMI goes to one of two active-low outputs, chosen by a routing bit. One is a dedicated pin. The other is a request for the IRQ2 slot of a serial interrupt stream. A software-visible bit can also make the SMI pull the PME output.

Firmware uses the block through a small register bus with eight byte addresses. Writes are strobed. Reads are combinational, and the read strobe is the clear event for read-clear bits.

Top module: `smi_pme_agg`

## Requirements
- R1: After an active-low asynchronous reset, every register reads 0 and `smi_n`, `irq2_n` and `pme_n` are 1.
- R2: Live status bits take their source's value at each clock edge and ignore bus writes. By default these are status A bits 0,1,2,3,7 and status B bits 0,1,4.
- R3: A read-clear status bit is set while its source is 1. A read strobe to its register clears it at the next edge. If the source is 1 in that same cycle, the bit stays set. By default these are status A bits 4,5 and status B bit 2.
- R4: A sticky status bit is set while its source is 1. It stays set after the source drops. It clears only when a bus write to its register carries a 1 in that bit position, and writing 0 there has no effect. By default these are status A bit 6 and status B bit 3.
- R5: The aggregated SMI is the enable-B bit 7 global gate ANDed with the OR of the following terms:
  - (status A AND enable A);
  - (status B[4:0] AND enable B[4:0]);
  - (`slp_evt` AND control bit 0).

  The aggregated SMI is registered, so a status bit set at edge k drives the output low after edge k+1.
- R6: Control bit 1 selects the SMI destination. With 0, `smi_n` carries the SMI and `irq2_n` stays 1. With 1, `irq2_n` carries it and `smi_n` stays 1.
- R7: Ring (`ring_evt`) and consumer IR (`evt_b[4]`) set sticky PME status bits 0 and 1. Those bits clear by writing 1 to them. `pme_n` goes low one edge after (PME status AND PME enable bits [1:0]) is nonzero, or one edge after the aggregated SMI is active while enable-B bit 6 is 1.
- R8: The register map is:

  | Address | Register | Readable/writable bits |
  |---|---|---|
  | 0 | status A | all |
  | 1 | status B | [4:0] |
  | 2 | enable A | all 8 bits writable |
  | 3 | enable B | bits 0-4, 6 and 7 writable |
  | 4 | PME status | [1:0] |
  | 5 | PME enable | [1:0] |
  | 6 | control | [1:0] |
  | 7 | none | reads 0 |

  All unlisted bits read 0.
- R9: Once the last enabled status term clears at edge k, the SMI and PME outputs return high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_a | input | 8 | Source events for status A |
| evt_b | input | 5 | Source events for status B (bit 4 is consumer IR) |
| ring_evt | input | 1 | Ring indication for PME status |
| slp_evt | input | 1 | Sleep request contributing to SMI |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (clears read-clear bits) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational |
| smi_n | output | 1 | Active-low SMI pin |
| irq2_n | output | 1 | Active-low IRQ2 serial-slot request |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The bench targets the following corner cases:

- **Read of a read-clear bit whose source is active in the same cycle.** A design that let the clear win would lose an event.
- **Write of 0 to a sticky bit, and write of any value to a live bit.** A design that decoded the write data loosely would drop or fake status.
- **Deassertion timing.** The bench measures it across the status and output registers. An unregistered or doubly registered aggregate shows up as a one-cycle error.
- **Routing bit and enable-B bits 6 and 7.** These are exercised under random traffic. Leaking SMI to both outputs, or to PME with the bit clear, gets caught against the bench's model.

// File: rtl/smi_pme_agg.sv
module smi_pme_agg #(
  parameter logic [7:0] RC_A  = 8'b0011_0000,
  parameter logic [7:0] W1C_A = 8'b0100_0000,
  parameter logic [4:0] RC_B  = 5'b0_0100,
  parameter logic [4:0] W1C_B = 5'b0_1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_a,
  input  logic [4:0] evt_b,
  input  logic       ring_evt,
  input  logic       slp_evt,
  input  logic [2:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       smi_n,
  output logic       irq2_n,
  output logic       pme_n
);
  localparam logic [2:0] A_STA = 3'd0, A_STB = 3'd1, A_ENA = 3'd2, A_ENB = 3'd3,
                         A_PST = 3'd4, A_PEN = 3'd5, A_CTL = 3'd6;
  localparam logic [7:0] ENB_MASK = 8'hDF;

  logic [7:0] sts_a, en_a, en_b, nx_a;
  logic [4:0] sts_b, nx_b;
  logic [1:0] pme_sts, pme_en, ctl;
  logic       smi_q, pme_q, smi_raw, pme_raw;

  wire rd_a = host_rd && host_addr == A_STA;
  wire rd_b = host_rd && host_addr == A_STB;
  wire wr_a = host_wr && host_addr == A_STA;
  wire wr_b = host_wr && host_addr == A_STB;

  for (genvar i = 0; i < 8; i++) begin : g_sa
    if (RC_A[i]) begin : g_rc
      assign nx_a[i] = evt_a[i] | (sts_a[i] & ~rd_a);
      AST_RC_CLEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a && !evt_a[i] |=> !sts_a[i]); // R3
      AST_RC_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a[i] |=> sts_a[i]); // R3
    end else if (W1C_A[i]) begin : g_w1c
      assign nx_a[i] = evt_a[i] | (sts_a[i] & ~(wr_a & host_wdata[i]));
      AST_W1C_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        sts_a[i] && !(wr_a && host_wdata[i]) |=> sts_a[i]); // R4
    end else begin : g_live
      assign nx_a[i] = evt_a[i];
      AST_LIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sts_a[i] == $past(evt_a[i])); // R2
    end
  end

  for (genvar i = 0; i < 5; i++) begin : g_sb
    if (RC_B[i]) begin : g_rc
      assign nx_b[i] = evt_b[i] | (sts_b[i] & ~rd_b);
      AST_RC_CLEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b && !evt_b[i] |=> !sts_b[i]); // R3
    end else if (W1C_B[i]) begin : g_w1c
      assign nx_b[i] = evt_b[i] | (sts_b[i] & ~(wr_b & host_wdata[i]));
      AST_W1C_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        sts_b[i] && !(wr_b && host_wdata[i]) |=> sts_b[i]); // R4
    end else begin : g_live
      assign nx_b[i] = evt_b[i];
      AST_LIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sts_b[i] == $past(evt_b[i])); // R2
    end
  end

  assign smi_raw = en_b[7] & (|(sts_a & en_a) | |(sts_b & en_b[4:0]) | (slp_evt & ctl[0]));
  assign pme_raw = |(pme_sts & pme_en) | (smi_raw & en_b[6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_a   <= '0;
      sts_b   <= '0;
      en_a    <= '0;
      en_b    <= '0;
      pme_sts <= '0;
      pme_en  <= '0;
      ctl     <= '0;
      smi_q   <= 1'b0;
      pme_q   <= 1'b0;
    end else begin
      sts_a   <= nx_a;
      sts_b   <= nx_b;
      pme_sts <= {evt_b[4], ring_evt} |
                 (pme_sts & ~((host_wr && host_addr == A_PST) ? host_wdata[1:0] : 2'b00));
      if (host_wr) begin
        case (host_addr)
          A_ENA: en_a   <= host_wdata;
          A_ENB: en_b   <= host_wdata & ENB_MASK;
          A_PEN: pme_en <= host_wdata[1:0];
          A_CTL: ctl    <= host_wdata[1:0];
          default: ;
        endcase
      end
      smi_q <= smi_raw;
      pme_q <= pme_raw;
    end
  end

  always_comb begin
    case (host_addr)
      A_STA:   host_rdata = sts_a;
      A_STB:   host_rdata = {3'b000, sts_b};
      A_ENA:   host_rdata = en_a;
      A_ENB:   host_rdata = en_b;
      A_PST:   host_rdata = {6'b0, pme_sts};
      A_PEN:   host_rdata = {6'b0, pme_en};
      A_CTL:   host_rdata = {6'b0, ctl};
      default: host_rdata = 8'h00;
    endcase
  end

  assign smi_n  = ~(smi_q & ~ctl[1]);
  assign irq2_n = ~(smi_q & ctl[1]);
  assign pme_n  = ~pme_q;

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b[7] |=> smi_n && irq2_n); // R5
  AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_q |-> $past(en_b[7])); // R5
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_n || irq2_n); // R6
  AST_PME_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    |(pme_sts & pme_en) |=> !pme_n); // R7
  AST_PME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pme_sts[0] && !(host_wr && host_addr == A_PST && host_wdata[0]) |=> pme_sts[0]); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en_b[5] == 1'b0); // R8
endmodule

// File: tb/tb_smi_pme_agg.sv
`timescale 1ns/1ps
module tb_smi_pme_agg;
  localparam logic [7:0] RCA = 8'b0011_0000, WCA = 8'b0100_0000;
  localparam logic [4:0] RCB = 5'b0_0100,    WCB = 5'b0_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] evt_a = '0, host_wdata = '0, host_rdata;
  logic [4:0] evt_b = '0;
  logic ring_evt = 1'b0, slp_evt = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic smi_n, irq2_n, pme_n;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_sa, m_ea, m_eb;
  logic [4:0] m_sb;
  logic [1:0] m_ps, m_pe, m_sc;
  logic m_smi, m_pme;

  smi_pme_agg dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_model(logic [2:0] a);
    case (a)
      3'd0: return m_sa;
      3'd1: return {3'b0, m_sb};
      3'd2: return m_ea;
      3'd3: return m_eb;
      3'd4: return {6'b0, m_ps};
      3'd5: return {6'b0, m_pe};
      3'd6: return {6'b0, m_sc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_sa = '0; m_sb = '0; m_ea = '0; m_eb = '0;
    m_ps = '0; m_pe = '0; m_sc = '0; m_smi = 0; m_pme = 0;
  endtask

  task automatic cyc(logic [7:0] a, logic [4:0] b, logic r, logic s,
                     logic [2:0] ad, logic w, logic rd, logic [7:0] wd);
    logic [7:0] na, ka, ea2, eb2;
    logic [4:0] nb, kb;
    logic [1:0] np, pe2, sc2;
    logic raw;
    evt_a = a; evt_b = b; ring_evt = r; slp_evt = s;
    host_addr = ad; host_wr = w; host_rd = rd; host_wdata = wd;
    #0.5;
    if (rd) check("R8 read data", host_rdata, rd_model(ad));
    ka = (RCA & ~((rd && ad == 3'd0) ? 8'hFF : 8'h00)) | (WCA & ~((w && ad == 3'd0) ? wd : 8'h00));
    kb = (RCB & ~((rd && ad == 3'd1) ? 5'h1F : 5'h00)) | (WCB & ~((w && ad == 3'd1) ? wd[4:0] : 5'h00));
    na = a | (m_sa & ka);
    nb = b | (m_sb & kb);
    np = {b[4], r} | (m_ps & ~((w && ad == 3'd4) ? wd[1:0] : 2'b00));
    raw = m_eb[7] & (|(m_sa & m_ea) | |(m_sb & m_eb[4:0]) | (s & m_sc[0]));
    ea2 = (w && ad == 3'd2) ? wd : m_ea;
    eb2 = (w && ad == 3'd3) ? (wd & 8'hDF) : m_eb;
    pe2 = (w && ad == 3'd5) ? wd[1:0] : m_pe;
    sc2 = (w && ad == 3'd6) ? wd[1:0] : m_sc;
    m_pme = |(m_ps & m_pe) | (raw & m_eb[6]);
    m_smi = raw;
    m_sa = na; m_sb = nb; m_ps = np; m_ea = ea2; m_eb = eb2; m_pe = pe2; m_sc = sc2;
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    check("R5 smi_n", {7'b0, smi_n}, {7'b0, ~(m_smi & ~m_sc[1])});
    check("R6 irq2_n", {7'b0, irq2_n}, {7'b0, ~(m_smi & m_sc[1])});
    check("R7 pme_n", {7'b0, pme_n}, {7'b0, ~m_pme});
  endtask

  task automatic peek(logic [2:0] ad, logic [7:0] exp, string tag);
    host_addr = ad; host_rd = 0; host_wr = 0;
    #0.5;
    check(tag, host_rdata, exp);
  endtask

  task automatic wr(logic [2:0] ad, logic [7:0] d);
    cyc(8'h00, 5'h00, 0, 0, ad, 1, 0, d);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 smi_n", {7'b0, smi_n}, 8'h01);
    check("R1 irq2_n", {7'b0, irq2_n}, 8'h01);
    check("R1 pme_n", {7'b0, pme_n}, 8'h01);
    for (int k = 0; k < 8; k++) peek(k[2:0], 8'h00, "R1 register reset");

    // R8 map and reserved bit
    wr(3'd3, 8'hFF);
    peek(3'd3, 8'hDF, "R8 enable B reserved bit5");
    wr(3'd2, 8'h80);
    peek(3'd2, 8'h80, "R8 enable A readback");
    wr(3'd6, 8'hFF);
    peek(3'd6, 8'h03, "R8 control width");
    wr(3'd6, 8'h00);
    wr(3'd3, 8'h80);

    // R2 live bit ignores writes and follows source
    cyc(8'h01, 5'h00, 0, 0, 3'd0, 1, 0, 8'hFF);
    peek(3'd0, 8'h01, "R2 live bit set");
    cyc(8'h01, 5'h00, 0, 0, 3'd0, 1, 0, 8'hFF);
    peek(3'd0, 8'h01, "R2 live bit ignores write");
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    peek(3'd0, 8'h00, "R2 live bit follows source low");

    // R3 read-clear: set during the read survives
    cyc(8'h10, 5'h00, 0, 0, 3'd0, 0, 1, 8'h00);
    peek(3'd0, 8'h10, "R3 set during read kept");
    cyc(8'h00, 5'h00, 0, 0, 3'd0, 0, 1, 8'h00);
    peek(3'd0, 8'h00, "R3 cleared by read");
    cyc(8'h00, 5'h04, 0, 0, 3'd7, 0, 0, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    peek(3'd1, 8'h04, "R3 read-clear B held without read");

    // R4 sticky
    cyc(8'h40, 5'h08, 0, 0, 3'd7, 0, 0, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd0, 1, 0, 8'hBF);
    peek(3'd0, 8'h40, "R4 write 0 to sticky bit ignored");
    cyc(8'h00, 5'h00, 0, 0, 3'd0, 0, 1, 8'h00);
    peek(3'd0, 8'h40, "R4 sticky survives read");
    cyc(8'h00, 5'h00, 0, 0, 3'd0, 1, 0, 8'h40);
    peek(3'd0, 8'h00, "R4 cleared by write 1");
    cyc(8'h00, 5'h00, 0, 0, 3'd1, 1, 0, 8'h08);
    cyc(8'h00, 5'h00, 0, 0, 3'd1, 0, 1, 8'h00);
    peek(3'd1, 8'h00, "R4 B sticky cleared");

    // R5 gating and R9 deassert timing
    wr(3'd3, 8'h00);
    cyc(8'h80, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    cyc(8'h80, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R5 gate off keeps smi high", {7'b0, smi_n}, 8'h01);
    cyc(8'h80, 5'h00, 0, 0, 3'd3, 1, 0, 8'h80);
    cyc(8'h80, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R5 smi asserted", {7'b0, smi_n}, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R9 smi still low one edge after clear", {7'b0, smi_n}, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R9 smi released", {7'b0, smi_n}, 8'h01);

    // R6 routing to serial slot, R7 smi-to-pme
    wr(3'd6, 8'h02);
    wr(3'd3, 8'hC0);
    cyc(8'h80, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R6 irq2_n low", {7'b0, irq2_n}, 8'h00);
    check("R6 smi_n high when routed away", {7'b0, smi_n}, 8'h01);
    check("R7 pme from smi", {7'b0, pme_n}, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    wr(3'd3, 8'h00);

    // R7 ring sticky into pme
    wr(3'd5, 8'h01);
    cyc(8'h00, 5'h00, 1, 0, 3'd7, 0, 0, 8'h00);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R7 ring drives pme", {7'b0, pme_n}, 8'h00);
    peek(3'd4, 8'h01, "R7 ring status sticky");
    cyc(8'h00, 5'h00, 0, 0, 3'd4, 1, 0, 8'h01);
    cyc(8'h00, 5'h00, 0, 0, 3'd7, 0, 0, 8'h00);
    check("R7 pme released after clear", {7'b0, pme_n}, 8'h01);

    // random traffic, sleep input with control bit 0
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ra, wd;
      logic [4:0] rb;
      logic [2:0] ad;
      logic w, rdx;
      ra = $urandom & $urandom & $urandom;
      rb = 5'($urandom & $urandom & $urandom);
      ad = 3'($urandom);
      wd = 8'($urandom);
      w = ($urandom % 6) == 0;
      rdx = ($urandom % 3) == 0;
      if (w && ad == 3'd3 && ($urandom % 2)) wd[7] = 1'b1;
      cyc(ra, rb, ($urandom % 9) == 0, ($urandom % 5) == 0, ad, w, rdx, wd);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule